// File: doc/BRIEF.md
# Bus Polarity Auto-Corrector

This block is the digital control core of a node on a two-wire, half-duplex differential bus whose wires may have been crossed during installation. Two analog comparators outside the block report whether the differential bus voltage lies above the positive receive threshold or below the negative one. The block turns these flags into a clean receive bit. It also forwards the local transmit bit and the two enables to the line driver and the receive output buffer.

After every reset the block assumes the wiring is correct. While the node only listens (driver off, receiver on), a timer measures how long the bus has rested below the negative threshold. A properly biased idle bus rests above the positive threshold, so a long negative rest means the wires are reversed. When the rest lasts the full failsafe window, the block inverts both the receive bit and the bit sent to the driver. One decision therefore serves both directions. Until the receiver enable is next released, the decision stays open: a sustained positive rest for the same window undoes it. A rising edge of the active-low receiver enable while corrected freezes the correction until the next reset.

The failsafe window is counted in clock cycles. The default of 7,500,000 cycles is 60 ms at a 125 MHz clock, which lies inside the 44 to 76 ms range expected of such nodes. The comparator flags are asynchronous to the clock and pass through a synchroniser before any logic uses them.

Top module: `bpc_top`

## Requirements
- R1: After reset the status flag `pol_inv` is 0 and no inversion is applied: `drv_data` equals `txd`, and `rxd` is 1 until a comparator flag arrives.
- R2: When `vid_neg` has been seen (after synchronisation) for FS_CYCLES consecutive clock cycles while `de`=0 and `re_n`=0, `pol_inv` becomes 1.
- R3: Any cycle in which the watched comparator flag is absent, `de` is 1 or `re_n` is 1 restarts the idle count from zero, so a full FS_CYCLES run is needed afterwards.
- R4: Uncorrected, `vid_pos` gives `rxd`=1 and `vid_neg` gives `rxd`=0. Corrected (`pol_inv`=1), `vid_pos` gives `rxd`=0 and `vid_neg` gives `rxd`=1.
- R5: Corrected, the transmit bit reaches the driver inverted: `txd`=1 gives `drv_data`=0 and `txd`=0 gives `drv_data`=1.
- R6: A 0-to-1 transition of `re_n` while `pol_inv`=1 locks the correction. After that no bus level changes `pol_inv` until reset.
- R7: Corrected but not locked, `vid_pos` seen for FS_CYCLES consecutive listening cycles returns `pol_inv` to 0.
- R8: When neither comparator flag is set, or both are, the receive bit holds its previous value.
- R9: A reset clears any correction, locked or not, and detection starts again.
- R10: `drv_oe` follows `de`, and `rxd_oe` is the inverse of `re_n`. A low output enable means that output is high-impedance.
- R11: Each comparator flag crosses a two-stage synchroniser. A flag change applied between clock edges changes `rxd` after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_pos | input | 1 | Comparator flag: differential input above positive threshold |
| vid_neg | input | 1 | Comparator flag: differential input below negative threshold |
| de | input | 1 | Driver enable, active high |
| re_n | input | 1 | Receiver enable, active low |
| txd | input | 1 | Transmit data bit from the local controller |
| rxd | output | 1 | Receive data bit, polarity corrected |
| rxd_oe | output | 1 | Output enable for `rxd` (0 = high-impedance) |
| drv_data | output | 1 | Data bit to the line driver, polarity corrected |
| drv_oe | output | 1 | Enable for the line driver (0 = high-impedance) |
| pol_inv | output | 1 | Status: 1 when the inversion is applied |

## Verification
The bench drives several negative rests: one broken by a single gap cycle, one broken by a short driver enable, and one long enough to run out the window. This separates a true continuous-run timer from one that merely accumulates. It then applies a sustained positive rest before and after a receiver-enable pulse, which distinguishes the open correction from the locked one. Transmit toggles in both polarities show that one decision governs both paths. Flag steps, gaps and simultaneous flags expose the synchroniser depth and the hold behaviour of the receive bit. A reset after locking shows that detection starts over.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  // Polarity decision states
  typedef enum logic [1:0] {
    PS_SEEK = 2'd0,  // wiring assumed straight, looking for negative rest
    PS_OPEN = 2'd1,  // inversion applied, may still be undone
    PS_LOCK = 2'd2   // inversion applied and frozen until reset
  } pol_state_t;

  function automatic logic pol_is_inverted(pol_state_t st);
    return (st != PS_SEEK);
  endfunction

endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gs == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_next
        always_comb stage_d = stage_q[gs-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[gs] <= {WIDTH{RST_VAL}};
        end else begin
          stage_q[gs] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[LAST];

endmodule

// File: rtl/bpc_idle_timer.sv
module bpc_idle_timer #(
  parameter int FS_CYCLES = 7_500_000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  output logic                         expire,
  output logic [$clog2(FS_CYCLES)-1:0] count
);

  localparam int CNT_W = $clog2(FS_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FS_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    expire = run && (cnt_q == LAST);
    cnt_en = run || (cnt_q != '0);
    if (!run || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/bpc_polarity_fsm.sv
module bpc_polarity_fsm
  import bpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       de,
  input  logic       re_n,
  input  logic       neg_s,
  input  logic       pos_s,
  input  logic       expire,
  output logic       run,
  output logic       inv,
  output pol_state_t state
);

  pol_state_t state_q;
  pol_state_t state_d;
  logic       re_prev_q;
  logic       listening;
  logic       re_release;
  logic       watched;

  always_comb begin
    listening  = !de && !re_n;
    re_release = re_n && !re_prev_q;
    unique case (state_q)
      PS_SEEK: watched = neg_s;
      PS_OPEN: watched = pos_s;
      default: watched = 1'b0;
    endcase
    run = listening && watched;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_SEEK: begin
        if (expire) state_d = PS_OPEN;
      end
      PS_OPEN: begin
        if (re_release)  state_d = PS_LOCK;
        else if (expire) state_d = PS_SEEK;
      end
      default: state_d = PS_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_SEEK;
      re_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      re_prev_q <= re_n;
    end
  end

  assign inv   = pol_is_inverted(state_q);
  assign state = state_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_LOCK) |=> (state_q == PS_LOCK)); // R6

  AST_ARM_ONLY_LISTENING: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_SEEK) && (de || re_n)) |=> (state_q == PS_SEEK)); // R2

  AST_REVERT_ONLY_LISTENING: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_OPEN) && (de || re_n)) |=> (state_q != PS_SEEK)); // R7

endmodule

// File: rtl/bpc_top.sv
module bpc_top
  import bpc_pkg::*;
#(
  parameter int FS_CYCLES   = 7_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_pos,
  input  logic vid_neg,
  input  logic de,
  input  logic re_n,
  input  logic txd,
  output logic rxd,
  output logic rxd_oe,
  output logic drv_data,
  output logic drv_oe,
  output logic pol_inv
);

  localparam int CNT_W = $clog2(FS_CYCLES);

  logic             rst_int_n;
  logic [1:0]       flags_s;
  logic             pos_s;
  logic             neg_s;
  logic             run;
  logic             expire;
  logic             inv;
  logic [CNT_W-1:0] idle_cnt;
  pol_state_t       state;
  logic             rx_q;
  logic             rx_d;
  logic             rx_en;

  // Reset release synchroniser
  bpc_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (1'b1),
    .q_sync  (rst_int_n)
  );

  // Comparator flag synchroniser
  bpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({vid_pos, vid_neg}),
    .q_sync  (flags_s)
  );

  assign pos_s = flags_s[1];
  assign neg_s = flags_s[0];

  bpc_idle_timer #(.FS_CYCLES(FS_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (run),
    .expire (expire),
    .count  (idle_cnt)
  );

  bpc_polarity_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .de     (de),
    .re_n   (re_n),
    .neg_s  (neg_s),
    .pos_s  (pos_s),
    .expire (expire),
    .run    (run),
    .inv    (inv),
    .state  (state)
  );

  // Receive level register: raw bus polarity, holds between thresholds
  always_comb begin
    rx_en = pos_s ^ neg_s;
    rx_d  = pos_s;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rx_q <= 1'b1;
    end else if (rx_en) begin
      rx_q <= rx_d;
    end
  end

  assign rxd      = rx_q ^ inv;
  assign rxd_oe   = !re_n;
  assign drv_data = txd ^ inv;
  assign drv_oe   = de;
  assign pol_inv  = inv;

  AST_ARM_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(inv) |-> ($past(idle_cnt) == CNT_W'(FS_CYCLES - 1))); // R2

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pos_s == neg_s) |=> $stable(rx_q)); // R8

  AST_LOCK_KEEPS_INV: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == PS_LOCK) |=> inv); // R6

endmodule

// File: tb/bpc_top_bench.sv
`timescale 1ns/1ps
module bpc_top_bench;

  localparam int FS = 16;

  logic clk = 1'b0;
  logic rst_n, vid_pos, vid_neg, de, re_n, txd;
  logic rxd, rxd_oe, drv_data, drv_oe, pol_inv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_r1, m_r2, m_n1, m_n2, m_p1, m_p2;
  int m_rx, m_st, m_cnt, m_reprev;

  always #4 clk = ~clk;

  bpc_top #(.FS_CYCLES(FS), .SYNC_STAGES(2)) u_bpc_top (
    .clk(clk), .rst_n(rst_n), .vid_pos(vid_pos), .vid_neg(vid_neg),
    .de(de), .re_n(re_n), .txd(txd), .rxd(rxd), .rxd_oe(rxd_oe),
    .drv_data(drv_data), .drv_oe(drv_oe), .pol_inv(pol_inv)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=hung exp=done");
      report();
    end
  end

  function automatic void m_reset();
    m_r1 = 0; m_r2 = 0; m_n1 = 0; m_n2 = 0; m_p1 = 0; m_p2 = 0;
    m_rx = 1; m_st = 0; m_cnt = 0; m_reprev = 1;
  endfunction

  function automatic void m_step();
    int listen, rise, watch, run, expire, nst;
    if (!rst_n) begin
      m_reset();
    end else if (m_r2 == 0) begin
      m_r2 = m_r1;
      m_r1 = 1;
    end else begin
      listen = (!de && !re_n) ? 1 : 0;
      rise   = (re_n && m_reprev == 0) ? 1 : 0;
      watch  = (m_st == 0) ? m_n2 : (m_st == 1) ? m_p2 : 0;
      run    = listen & watch;
      expire = (run == 1 && m_cnt == FS - 1) ? 1 : 0;
      nst = m_st;
      if (m_st == 1 && rise == 1) nst = 2;
      else if (expire == 1) nst = (m_st == 0) ? 1 : 0;
      m_cnt = (run == 1 && expire == 0) ? m_cnt + 1 : 0;
      if (m_p2 == 1 && m_n2 == 0) m_rx = 1;
      else if (m_n2 == 1 && m_p2 == 0) m_rx = 0;
      m_st = nst;
      m_reprev = re_n ? 1 : 0;
      m_n2 = m_n1; m_n1 = vid_neg ? 1 : 0;
      m_p2 = m_p1; m_p1 = vid_pos ? 1 : 0;
    end
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic inv;
    inv = (m_st != 0);
    chk(cur_req, "pol_inv", pol_inv, inv);
    chk(cur_req, "drv_data", drv_data, txd ^ inv);
    chk(cur_req, "drv_oe", drv_oe, de);
    chk(cur_req, "rxd_oe", rxd_oe, !re_n);
    chk(cur_req, "rxd", rxd, logic'(m_rx) ^ inv);
  endtask

  // Advance n clock edges; inputs change only 1 ns after an edge
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      m_step();
      #1;
      compare_model();
    end
  endtask

  task automatic bus(logic p, logic n);
    vid_pos = p;
    vid_neg = n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_reset();
    #1;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    rst_n = 1'b0; vid_pos = 1'b0; vid_neg = 1'b0;
    de = 1'b0; re_n = 1'b0; txd = 1'b1;
    m_reset();
    @(posedge clk); #1;
    cur_req = "R1";
    do_reset();
    chk("R1", "pol_inv after reset", pol_inv, 1'b0);
    chk("R1", "rxd after reset", rxd, 1'b1);
    chk("R1", "drv_data=txd", drv_data, 1'b1);
    txd = 1'b0; #1;
    chk("R1", "drv_data=txd low", drv_data, 1'b0);

    // Synchroniser depth and uncorrected receive
    cur_req = "R11";
    bus(1'b0, 1'b1); cyc(5);
    chk("R4", "uncorrected neg -> rxd 0", rxd, 1'b0);
    bus(1'b1, 1'b0); cyc(2);
    chk("R11", "rxd unchanged after 2 edges", rxd, 1'b0);
    cyc(1);
    chk("R11", "rxd changed after 3 edges", rxd, 1'b1);
    chk("R4", "uncorrected pos -> rxd 1", rxd, 1'b1);

    // Hold between thresholds
    cur_req = "R8";
    bus(1'b0, 1'b0); cyc(6);
    chk("R8", "hold high", rxd, 1'b1);
    bus(1'b0, 1'b1); cyc(4);
    bus(1'b1, 1'b1); cyc(5);
    chk("R8", "both flags hold low", rxd, 1'b0);
    bus(1'b0, 1'b0); cyc(5);
    chk("R8", "hold low", rxd, 1'b0);

    // Broken negative rests
    cur_req = "R3";
    bus(1'b0, 1'b1); cyc(10);
    bus(1'b0, 1'b0); cyc(1);
    bus(1'b0, 1'b1); cyc(10);
    chk("R3", "gap cycle restarts count", pol_inv, 1'b0);
    de = 1'b1; cyc(1);
    de = 1'b0; cyc(10);
    chk("R3", "driver enable restarts count", pol_inv, 1'b0);
    re_n = 1'b1; cyc(1);
    re_n = 1'b0; cyc(10);
    chk("R3", "receiver disable restarts count", pol_inv, 1'b0);

    // Full window arms the correction
    cur_req = "R2";
    cyc(12);
    chk("R2", "pol_inv set after window", pol_inv, 1'b1);
    chk("R4", "corrected neg -> rxd 1", rxd, 1'b1);
    bus(1'b1, 1'b0); cyc(4);
    cur_req = "R4";
    chk("R4", "corrected pos -> rxd 0", rxd, 1'b0);

    // Transmit path inversion
    cur_req = "R5";
    de = 1'b1; txd = 1'b1; cyc(2);
    chk("R5", "txd 1 -> drv 0", drv_data, 1'b0);
    chk("R10", "drv_oe high", drv_oe, 1'b1);
    txd = 1'b0; cyc(2);
    chk("R5", "txd 0 -> drv 1", drv_data, 1'b1);
    de = 1'b0; cyc(1);
    chk("R10", "drv_oe low", drv_oe, 1'b0);

    // Revert while open
    cur_req = "R7";
    cyc(20);
    chk("R7", "positive rest reverts", pol_inv, 1'b0);
    chk("R7", "rxd normal after revert", rxd, 1'b1);
    bus(1'b0, 1'b1); cur_req = "R2"; cyc(25);
    chk("R2", "re-armed", pol_inv, 1'b1);

    // Lock on receiver-enable release
    cur_req = "R6";
    re_n = 1'b1; cyc(3);
    chk("R10", "rxd_oe low when re_n high", rxd_oe, 1'b0);
    re_n = 1'b0; cyc(1);
    chk("R10", "rxd_oe high", rxd_oe, 1'b1);
    bus(1'b1, 1'b0); cyc(40);
    chk("R6", "locked against positive rest", pol_inv, 1'b1);
    chk("R6", "locked rxd inverted", rxd, 1'b0);
    de = 1'b1; txd = 1'b1; cyc(2);
    chk("R6", "locked drv inverted", drv_data, 1'b0);
    de = 1'b0;

    // Reset restarts detection
    cur_req = "R9";
    do_reset();
    chk("R9", "reset clears lock", pol_inv, 1'b0);
    chk("R9", "drv_data follows txd", drv_data, 1'b1);
    bus(1'b0, 1'b1); cyc(25);
    chk("R9", "detection after reset", pol_inv, 1'b1);

    report();
  end

endmodule